// File: doc/BRIEF.md
# Converter Result Formatter with Range Decode

This block sits between the back end of a 14-bit pipelined converter and its parallel result bus. For every sample clock it accepts a raw offset-binary code and a one-bit out-of-range flag. The code and the flag travel together through one matched delay line, so that they leave the block in the same cycle, a fixed number of clock edges after the sample was taken.

At the output the block applies the selected number coding, either offset binary or two's complement. It also splits the range flag into separate over-range and under-range indicators by combining it with the top bit of the offset-binary code. A calibration sequencer can hold the results at zero through a force-zero input. A disable input turns off the enable that the bus drivers use, which leaves the data lines floating.

Top module: `adc_fmt_top`

## Requirements
- R1: A code presented on `raw_code` at a rising clock edge appears on `data_out` after the 7th rising edge from that one, and on no earlier edge. The bit order is kept, with bit 13 as the MSB.
- R2: The `raw_oor` flag sampled with a code is delayed by exactly the same 7 edges. The range indicators therefore always describe the word shown on `data_out` in the same cycle.
- R3: When `fmt_twos` is 0, `data_out` equals the delayed offset-binary code unchanged. Code 0x0000 is the most negative value and 0x3FFF is the most positive.
- R4: When `fmt_twos` is 1, `data_out` is the delayed code with bit 13 inverted and bits 12..0 unchanged. For example, 0x2000 becomes 0x0000 and 0x1FFF becomes 0x3FFF. `fmt_twos` acts on the current output cycle without any delay.
- R5: `over_range` is 1 exactly when the delayed flag is 1 and bit 13 of the delayed offset-binary code is 1. This holds for either setting of `fmt_twos`.
- R6: `under_range` is 1 exactly when the delayed flag is 1 and bit 13 of the delayed offset-binary code is 0. This holds for either setting of `fmt_twos`. `over_range` and `under_range` are never 1 together.
- R7: `data_oe` is 0 while `out_disable` is 1, which makes the bus high-impedance, and 1 while `out_disable` is 0. `out_disable` has no effect on `data_out`, `over_range` or `under_range`.
- R8: While `force_zero` is 1, `data_out`, `over_range` and `under_range` are all 0 in the same cycle. The delay line keeps shifting during that time, so delayed samples reappear as soon as `force_zero` returns to 0.
- R9: While `rst_n` is low the delay line is cleared, so that code 0 with flag 0 is presented. Until 7 edges after reset release, `data_out` shows code 0 in the selected coding and both range indicators are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; rising edge captures |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_code | input | 14 | Raw offset-binary conversion result |
| raw_oor | input | 1 | Out-of-range flag for the same sample |
| fmt_twos | input | 1 | 0 = offset binary, 1 = two's complement |
| out_disable | input | 1 | 1 = release the data bus (high-impedance) |
| force_zero | input | 1 | 1 = zero the data and both range indicators |
| data_out | output | 14 | Formatted result word |
| data_oe | output | 1 | Drive enable for the data bus pads |
| over_range | output | 1 | Sample was above the top of the range |
| under_range | output | 1 | Sample was below the bottom of the range |

## Verification
The hardest case is to show that the range decode does not depend on the coding. This needs an out-of-range sample whose top bit differs from the output MSB, and the coding select has to change in the cycle in which that sample comes out of the delay line. The stimulus toggles `fmt_twos` independently in every cycle while it drives directed end-of-scale codes (0x0000, 0x3FFF, 0x1FFF, 0x2000) with the flag set. It also places force-zero windows while flagged samples are still inside the delay line, so that the bench can see them reappear once the window closes.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

    typedef enum logic {
        FMT_OFFSET = 1'b0,
        FMT_TWOS   = 1'b1
    } fmt_e;

endpackage

// File: rtl/adc_fmt_delay.sv
module adc_fmt_delay #(
    parameter int WIDTH = 14,
    parameter int DEPTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_code,
    input  logic             in_flag,
    output logic [WIDTH-1:0] out_code,
    output logic             out_flag
);

    localparam int LAST = DEPTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] code;
        logic             flag;
    } tap_t;

    tap_t [DEPTH-1:0] taps_d;
    tap_t [DEPTH-1:0] taps_q;

    always_comb begin
        taps_d         = taps_q;
        taps_d[0].code = in_code;
        taps_d[0].flag = in_flag;
        for (int i = 1; i < DEPTH; i++) begin
            taps_d[i] = taps_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taps_q <= '0;
        end else begin
            taps_q <= taps_d;
        end
    end

    assign out_code = taps_q[LAST].code;
    assign out_flag = taps_q[LAST].flag;

    // R1 and R2: first tap takes code and flag from the same edge
    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (taps_q[0].code == $past(in_code)) &&
                         (taps_q[0].flag == $past(in_flag)));

    generate
        for (genvar g = 1; g < DEPTH; g++) begin : g_shift_chk
            // R1: every tap moves one place per edge, code and flag together
            assert_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> taps_q[g] == $past(taps_q[g-1]));
        end
    endgenerate

endmodule

// File: rtl/adc_fmt_encode.sv
module adc_fmt_encode #(
    parameter int WIDTH = 14
) (
    input  logic [WIDTH-1:0]       code,
    input  logic                   flag,
    input  adc_fmt_pkg::fmt_e      fmt,
    input  logic                   force_zero,
    output logic [WIDTH-1:0]       word,
    output logic                   over,
    output logic                   under
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] coded;
    logic             top_bit;

    always_comb begin
        top_bit = code[MSB];
        coded   = code;
        if (fmt == adc_fmt_pkg::FMT_TWOS) begin
            coded[MSB] = ~top_bit;
        end
        if (force_zero) begin
            word  = '0;
            over  = 1'b0;
            under = 1'b0;
        end else begin
            word  = coded;
            over  = flag & top_bit;
            under = flag & ~top_bit;
        end
    end

    always_comb begin
        // R6: the two indicators exclude each other
        assert_exclusive_R6: assert ($onehot0({over, under}));
        // R8: forced cycles present nothing
        if (force_zero) begin
            assert_forced_R8: assert (word == '0 && !over && !under);
        end else begin
            // R4: output MSB follows the coding select against the raw MSB
            assert_msb_fmt_R4: assert (word[MSB] == (code[MSB] ^ (fmt == adc_fmt_pkg::FMT_TWOS)));
            // R5: any indicator implies the delayed flag
            assert_flag_src_R5: assert (!(over || under) || flag);
        end
    end

endmodule

// File: rtl/adc_fmt_top.sv
module adc_fmt_top #(
    parameter int CODE_W  = 14,
    parameter int LATENCY = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] raw_code,
    input  logic              raw_oor,
    input  logic              fmt_twos,
    input  logic              out_disable,
    input  logic              force_zero,
    output logic [CODE_W-1:0] data_out,
    output logic              data_oe,
    output logic              over_range,
    output logic              under_range
);

    logic [CODE_W-1:0]  dly_code;
    logic               dly_flag;
    adc_fmt_pkg::fmt_e  fmt_sel;

    assign fmt_sel = fmt_twos ? adc_fmt_pkg::FMT_TWOS : adc_fmt_pkg::FMT_OFFSET;

    adc_fmt_delay #(
        .WIDTH (CODE_W),
        .DEPTH (LATENCY)
    ) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_code  (raw_code),
        .in_flag  (raw_oor),
        .out_code (dly_code),
        .out_flag (dly_flag)
    );

    adc_fmt_encode #(
        .WIDTH (CODE_W)
    ) u_encode (
        .code       (dly_code),
        .flag       (dly_flag),
        .fmt        (fmt_sel),
        .force_zero (force_zero),
        .word       (data_out),
        .over       (over_range),
        .under      (under_range)
    );

    assign data_oe = ~out_disable;

    // R8: the delay line keeps running under force-zero; once it drops, the
    // low bits come straight from the delay line again
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !force_zero |-> data_out[CODE_W-2:0] == dly_code[CODE_W-2:0]);

endmodule

// File: tb/adc_fmt_top_tb.sv
module adc_fmt_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] raw_code = '0;
    logic        raw_oor = 1'b0;
    logic        fmt_twos = 1'b0;
    logic        out_disable = 1'b0;
    logic        force_zero = 1'b0;
    logic [13:0] data_out;
    logic        data_oe;
    logic        over_range;
    logic        under_range;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [13:0] h_code [8];
    logic        h_flag [8];

    always #4 clk = ~clk;

    adc_fmt_top u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .raw_code    (raw_code),
        .raw_oor     (raw_oor),
        .fmt_twos    (fmt_twos),
        .out_disable (out_disable),
        .force_zero  (force_zero),
        .data_out    (data_out),
        .data_oe     (data_oe),
        .over_range  (over_range),
        .under_range (under_range)
    );

    function automatic logic [13:0] exp_word(logic [13:0] c, logic f, logic fz);
        if (fz) return 14'h0;
        return {c[13] ^ f, c[12:0]};
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual 0x%0h expected 0x%0h", tag, cyc, act, exp);
        end
    endtask

    // compare outputs with the sample driven 7 cycles back, then drive the next
    task automatic step(logic [13:0] c, logic fl, logic fmt, logic dis, logic fz);
        int idx;
        logic [13:0] ec;
        logic        ef;
        @(negedge clk);
        idx = (cyc + 1) & 7;
        ec  = h_code[idx];
        ef  = h_flag[idx];
        if (force_zero) chk("R8 data", int'(data_out), 0);
        else if (fmt_twos) chk("R1 R4 data", int'(data_out), int'(exp_word(ec, 1'b1, 1'b0)));
        else chk("R1 R3 data", int'(data_out), int'(exp_word(ec, 1'b0, 1'b0)));
        chk("R2 R5 over", int'(over_range), int'(!force_zero && ef && ec[13]));
        chk("R2 R6 under", int'(under_range), int'(!force_zero && ef && !ec[13]));
        chk("R7 oe", int'(data_oe), int'(!out_disable));
        raw_code       = c;
        raw_oor        = fl;
        fmt_twos       = fmt;
        out_disable    = dis;
        force_zero     = fz;
        h_code[cyc & 7] = c;
        h_flag[cyc & 7] = fl;
        cyc++;
    endtask

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            h_code[i] = '0;
            h_flag[i] = 1'b0;
        end
        void'($urandom(32'd20481));
        // R9: held in reset while the raw input carries a flagged full-scale code
        raw_code = 14'h3FFF;
        raw_oor  = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset data", int'(data_out), 0);
        chk("R9 reset over", int'(over_range), 0);
        fmt_twos = 1'b1;
        #1;
        chk("R9 reset data twos", int'(data_out), 'h2000);
        fmt_twos = 1'b0;
        raw_code = '0;
        raw_oor  = 1'b0;
        rst_n    = 1'b1;

        // directed end-of-scale samples with the coding select toggled
        step(14'h0000, 1'b1, 1'b0, 1'b0, 1'b0); // under-range
        step(14'h3FFF, 1'b1, 1'b1, 1'b0, 1'b0); // over-range
        step(14'h2000, 1'b0, 1'b0, 1'b0, 1'b0);
        step(14'h1FFF, 1'b1, 1'b1, 1'b0, 1'b0);
        step(14'h2000, 1'b1, 1'b0, 1'b1, 1'b0);
        step(14'h1FFF, 1'b0, 1'b1, 1'b0, 1'b0);
        step(14'h0001, 1'b0, 1'b0, 1'b0, 1'b0);
        // flagged samples come out while the coding flips each cycle
        for (int k = 0; k < 8; k++) step(14'h0000, 1'b0, k[0], 1'b0, 1'b0);
        // R8: force-zero while flagged samples are in flight
        step(14'h3FFF, 1'b1, 1'b0, 1'b0, 1'b0);
        step(14'h0000, 1'b1, 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 6; k++) step(14'h1234, 1'b0, 1'b0, 1'b0, 1'b1);
        for (int k = 0; k < 8; k++) step(14'h0ABC, 1'b0, k[0], k[1], 1'b0);

        // random traffic
        for (int k = 0; k < 4000; k++) begin
            logic [13:0] c;
            int r;
            r = int'($urandom_range(0, 9));
            c = 14'($urandom());
            if (r == 0) c = 14'h3FFF;
            if (r == 1) c = 14'h0000;
            step(c, ($urandom_range(0, 3) == 0), 1'($urandom()),
                 ($urandom_range(0, 4) == 0), ($urandom_range(0, 9) == 0));
        end
        step(14'h0, 1'b0, 1'b0, 1'b0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule